// File: doc/BRIEF.md
# Interval Timer with Compare-and-Wrap

This block is a 32-bit interval timer. Three registers sit behind a single-cycle register port: a running count, a compare limit and a small control word. While the run bit is set, the count steps by one on every clock. When the count equals the limit, it returns to zero on the next step, so one interval lasts limit+1 clocks. If the interrupt-enable bit is set, the wrap also raises a sticky event flag, and that flag drives the interrupt output.

Software sets an interval in three steps: it writes the limit, writes the count (usually to zero) and then writes the control word. Any write to the control word clears a pending event, whatever value is written. In the interrupt handler, one control write therefore acknowledges the event and also keeps the timer running or stops it. With the limit at all ones, the block is a free-running 32-bit counter that wraps.

Top module: `cnt_limit_timer`

## Requirements
- R1: After reset the count, the limit and every control bit are zero, and `irq` is low.
- R2: While the run bit (control bit 1) is clear and the count is not written, the count keeps its value.
- R3: While the run bit is set, the count increases by one per clock. When it equals the limit it becomes zero on the next clock, so the period is limit+1 clocks.
- R4: A wrap while the enable bit (control bit 0) is set raises the pending flag (control bit 3) and `irq` on the clock after the match. Both stay high until a control write.
- R5: A wrap while the enable bit is clear leaves the pending flag and `irq` low.
- R6: Every write to the control register clears the pending flag on that clock, for any written value, including one that stops the timer.
- R7: When a control write and a match fall on the same clock, the clear wins. The next match raises the flag again.
- R8: A write to the count register loads the written value on that clock and takes precedence over the step.
- R9: With the limit at 0xFFFFFFFF, the count runs through 0xFFFFFFFF to 0 and keeps counting.
- R10: Register addresses are count = 0, limit = 1 and control = 2. Control bits 0 and 1 read back as written, bit 3 is the read-only pending flag, and all other bits read zero. Address 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, high while an event is pending |

## Verification
The in-design assertions check the per-clock rules on every cycle:
- the count holds, steps, wraps or loads as R2, R3 and R8 require;
- the pending flag sets, stays and clears as R4, R5 and R6 require.

Only the bench scenarios can show the behaviours that span many cycles or depend on the bus:
- the exact interval length seen at `irq`;
- a control write that lands on the matching clock, and the match after it;
- the free-running wrap through the top value;
- the read-back encoding, including the unused address.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // Register select values
    localparam int unsigned SEL_COUNT = 0;
    localparam int unsigned SEL_LIMIT = 1;
    localparam int unsigned SEL_CTRL  = 2;

    // Control word bit positions
    localparam int unsigned BIT_IE   = 0;
    localparam int unsigned BIT_RUN  = 1;
    localparam int unsigned BIT_PEND = 3;

    typedef struct packed {
        logic ie;
        logic run;
        logic pend;
    } ctrl_state_t;
endpackage

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cnt_we,
    input  logic              lim_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              hit
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] limit;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = run && (st_q.count == st_q.limit);
        if (cnt_we) begin
            st_d.count = wdata;
        end else if (run) begin
            st_d.count = hit ? '0 : st_q.count + 1'b1;
        end
        if (lim_we) begin
            st_d.limit = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign limit_q = st_q.limit;

    p_reset_r1: assert property (@(posedge clk) rst |=> (count_q == '0 && limit_q == '0));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(count_q));
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_we && count_q != limit_q) |=> count_q == $past(count_q) + 1'b1);
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_we && count_q == limit_q) |=> count_q == '0);
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> count_q == $past(wdata));
    p_limit_r10: assert property (@(posedge clk) disable iff (rst)
        !lim_we |=> $stable(limit_q));
endmodule

// File: rtl/tmr_ctrl_unit.sv
module tmr_ctrl_unit
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hit,
    output logic              ie,
    output logic              run,
    output logic              pending
);
    ctrl_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (ctrl_we) begin
            // acknowledge has priority over a same-cycle event
            cs_d.ie   = wdata[BIT_IE];
            cs_d.run  = wdata[BIT_RUN];
            cs_d.pend = 1'b0;
        end else if (hit && cs_q.ie) begin
            cs_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ie      = cs_q.ie;
    assign run     = cs_q.run;
    assign pending = cs_q.pend;

    p_reset_r1: assert property (@(posedge clk) rst |=> (!ie && !run && !pending));
    p_raise_r4: assert property (@(posedge clk) disable iff (rst)
        (hit && ie && !ctrl_we) |=> pending);
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (pending && !ctrl_we) |=> pending);
    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!ie && !pending) |=> !pending);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> !pending);
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] count_q,
    input  logic [DATA_W-1:0] limit_q,
    input  logic              ie,
    input  logic              run,
    input  logic              pending,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[BIT_IE]   = ie;
        ctrl_word[BIT_RUN]  = run;
        ctrl_word[BIT_PEND] = pending;
        unique case (addr)
            ADDR_W'(SEL_COUNT): rdata = count_q;
            ADDR_W'(SEL_LIMIT): rdata = limit_q;
            ADDR_W'(SEL_CTRL):  rdata = ctrl_word;
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/cnt_limit_timer.sv
module cnt_limit_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              we_count, we_limit, we_ctrl;
    logic [DATA_W-1:0] count_q, limit_q;
    logic              hit, ie, run, pending;

    always_comb begin
        we_count = bus_we && (bus_addr == ADDR_W'(SEL_COUNT));
        we_limit = bus_we && (bus_addr == ADDR_W'(SEL_LIMIT));
        we_ctrl  = bus_we && (bus_addr == ADDR_W'(SEL_CTRL));
    end

    tmr_count_unit #(.DATA_W(DATA_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .cnt_we  (we_count),
        .lim_we  (we_limit),
        .wdata   (bus_wdata),
        .count_q (count_q),
        .limit_q (limit_q),
        .hit     (hit)
    );

    tmr_ctrl_unit #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_we (we_ctrl),
        .wdata   (bus_wdata),
        .hit     (hit),
        .ie      (ie),
        .run     (run),
        .pending (pending)
    );

    tmr_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .addr    (bus_addr),
        .count_q (count_q),
        .limit_q (limit_q),
        .ie      (ie),
        .run     (run),
        .pending (pending),
        .rdata   (bus_rdata)
    );

    assign irq = pending;

    p_irq_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && !we_ctrl) |=> irq);
endmodule

// File: tb/tb_cnt_limit_timer.sv
module tb_cnt_limit_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;
    bit started = 0;

    always #10 clk = ~clk;

    cnt_limit_timer dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    // behavioural reference, updated at each rising edge
    logic [31:0] m_cnt, m_lim;
    logic        m_ie, m_run, m_pend;

    always @(posedge clk) begin : model
        logic h;
        if (rst) begin
            m_cnt = 0; m_lim = 0; m_ie = 0; m_run = 0; m_pend = 0;
            started = 1;
        end else begin
            h = m_run && (m_cnt == m_lim);
            if (we && addr == 2'd0) m_cnt = wdata;
            else if (m_run) m_cnt = h ? 32'd0 : m_cnt + 32'd1;
            if (we && addr == 2'd1) m_lim = wdata;
            if (we && addr == 2'd2) begin
                m_pend = 0; m_ie = wdata[0]; m_run = wdata[1];
            end else if (h && m_ie) m_pend = 1;
        end
    end

    function automatic logic [31:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_lim;
            2'd2: return {28'd0, m_pend, 1'b0, m_run, m_ie};
            default: return 32'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (started && !rst) begin
            checks++;
            if (rdata !== model_rd(addr) || irq !== m_pend) begin
                errors++;
                $display("FAIL R3 R4 R10 model: rdata %h irq %b expected %h %b",
                         rdata, irq, model_rd(addr), m_pend);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        @(negedge clk);
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); chk("R1 count", v, 0);
        rd(2'd1, v); chk("R1 limit", v, 0);
        rd(2'd2, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 halted count holds
        wr(2'd0, 32'd5);
        idle(4);
        rd(2'd0, v); chk("R2 hold", v, 5);

        // R3/R4 interval of limit+1, then sticky pending
        wr(2'd1, 32'd3);
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h3);
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R3 no irq before wrap", {31'd0, irq}, 0);
        @(negedge clk); chk("R4 irq after wrap", {31'd0, irq}, 1);
        rd(2'd2, v); chk("R10 ctrl readback with pending", v, 32'hB);
        idle(10);
        chk("R4 irq sticky", {31'd0, irq}, 1);

        // R6 clear by any control write
        wr(2'd2, 32'h3);
        @(negedge clk); chk("R6 clear rearm", {31'd0, irq}, 0);
        idle(6);
        chk("R4 raised again", {31'd0, irq}, 1);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk("R6 clear with zero write", v, 0);
        rd(2'd0, v);
        idle(5);
        begin
            logic [31:0] v2;
            rd(2'd0, v2); chk("R2 hold after stop", v2, v);
        end

        // R5 enable clear: no event
        wr(2'd1, 32'd2);
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h2);
        idle(20);
        chk("R5 no irq", {31'd0, irq}, 0);

        // R7 control write on the matching clock
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd4);
        wr(2'd0, 32'd0);
        wr(2'd2, 32'h3);     // run from edge E
        idle(3);
        wr(2'd2, 32'h3);     // captured on edge E+5, the first match
        @(negedge clk); chk("R7 clear wins", {31'd0, irq}, 0);
        repeat (4) @(posedge clk);
        @(negedge clk); chk("R7 before next match", {31'd0, irq}, 0);
        @(negedge clk); chk("R7 next match raises", {31'd0, irq}, 1);

        // R8 count write overrides step
        wr(2'd1, 32'd200);
        wr(2'd0, 32'd100);
        rd(2'd0, v); chk("R8 load", v, 100);
        @(negedge clk); chk("R8 step after load", rdata, 101);

        // R9 free-running wrap through the top value
        wr(2'd2, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFD);
        wr(2'd2, 32'h2);
        addr = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R9 wrapped to zero", rdata, 0);
        @(negedge clk); chk("R9 keeps counting", rdata, 1);

        // R10 unused address and control bit masking
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd77);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); chk("R10 addr3 reads zero", v, 0);
        rd(2'd1, v); chk("R10 addr3 write ignored", v, 77);
        wr(2'd2, 32'hFFFF_FFF5);
        rd(2'd2, v); chk("R10 ctrl masking", v, 32'h1);

        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule